// File: doc/BRIEF.md
# Presettable Up-Counter with Terminal-Count Reload

This block is a synchronous binary up-counter, 8 bits wide by default, that can be loaded in parallel from a preset bus. Counting is enabled by an active-low input. An active-low terminal-count output goes low while the count holds all ones. A reload-control input decides what happens at that terminal state. With reload-control low, the counter rolls over to zero and keeps counting. With reload-control high, it takes the preset value again, so it divides the clock by (2^WIDTH − preset).

An active-high clear input resets the count to zero at once, without waiting for a clock edge. Wider counters are built from several slices on one clock. Each slice's enable is the OR of the enable of the slice below it and the terminal-count output of that slice. A slice therefore advances only when all lower slices are at all ones, and it advances on the same edge on which they roll over.

Top module: `reload_counter`

## Requirements
- R1: When `load_n` is 0, the next rising clock edge puts `preset` into `q`, whatever the values of `count_en_n` and `reload_en`.
- R2: When `load_n` is 1, `count_en_n` is 0 and `q` is not all ones, each rising edge raises `q` by exactly one.
- R3: When `load_n` is 1 and `count_en_n` is 1, `q` keeps its value. This holds at all ones with `reload_en` 1 as well.
- R4: `term_n` is 0 exactly when `q` equals all ones (8'hFF at the default width), whatever the value of `count_en_n`.
- R5: With `reload_en` 0, counting enabled and `q` all ones, the next edge gives `q` = 0.
- R6: With `reload_en` 1, counting enabled and `q` all ones, the next edge loads `preset`. The count then repeats every 2^WIDTH − preset clocks (10 clocks for preset 8'hF6).
- R7: While `clear` is 1, `q` is 0 and `term_n` is 1 without waiting for a clock edge, and this overrides every other input.
- R8: When slices are chained with slice k's `count_en_n` equal to the OR of the lower slices' `term_n` and the base enable, the chain counts as one wide binary counter. At 32'h00FFFFFF, the next enabled edge gives 32'h01000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Asynchronous active-high reset of the count |
| load_n | input | 1 | Active-low parallel load; takes priority over counting |
| count_en_n | input | 1 | Active-low count enable |
| reload_en | input | 1 | 1: reload the preset at all ones; 0: roll over to zero |
| preset | input | WIDTH | Parallel preset value |
| q | output | WIDTH | Current count |
| term_n | output | 1 | Active-low terminal count, low when `q` is all ones |

## Verification
A free run of more than 256 clocks starts from 8'hF0 with reload disabled, so it crosses the roll-over boundary twice. This separates plain increment from wrap behaviour. A reload run with preset 8'hF6 measures the spacing between terminal-count pulses, which shows whether the terminal edge reloads or rolls over. Load is applied while counting and while holding to show that it takes priority. A hold at all ones with reload armed shows that the enable gates the reload. A clear raised in the middle of a cycle, and a four-slice chain stepped through 32'h00FFFFFF, check the asynchronous override and a carry that crosses several slices on the same edge.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_LOAD   = 3'd1,
    ACT_STEP   = 3'd2,
    ACT_WRAP   = 3'd3,
    ACT_RELOAD = 3'd4
  } rlc_act_e;

  // Priority: load, then hold, then the end-of-count choice.
  function automatic rlc_act_e rlc_pick(logic load_n, logic cnt_en_n,
                                        logic reload_en, logic at_top);
    if (!load_n)   return ACT_LOAD;
    if (cnt_en_n)  return ACT_HOLD;
    if (!at_top)   return ACT_STEP;
    if (reload_en) return ACT_RELOAD;
    return ACT_WRAP;
  endfunction

endpackage

// File: rtl/rlc_term_dec.sv
module rlc_term_dec #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q,
  output logic             at_top,
  output logic             term_n
);
  // Decoded from the registered count only.
  assign at_top = &q;
  assign term_n = ~at_top;
endmodule

// File: rtl/rlc_next_sel.sv
module rlc_next_sel
  import rlc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] preset,
  input  rlc_act_e         act,
  output logic [WIDTH-1:0] q_nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (act)
      ACT_LOAD, ACT_RELOAD: q_nxt = preset;
      ACT_STEP:             q_nxt = q + ONE;
      ACT_WRAP:             q_nxt = '0;
      default:              q_nxt = q;
    endcase
  end
endmodule

// File: rtl/rlc_state_reg.sv
module rlc_state_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or posedge clear) begin
    if (clear) q <= '0;
    else       q <= d;
  end
endmodule

// File: rtl/reload_counter.sv
module reload_counter
  import rlc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             load_n,
  input  logic             count_en_n,
  input  logic             reload_en,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q,
  output logic             term_n
);
  logic [WIDTH-1:0] q_nxt;
  logic             at_top;
  rlc_act_e         act;

  // Named events for the checker.
  logic evt_load, evt_step, evt_wrap, evt_reload, evt_hold;

  rlc_term_dec #(.WIDTH(WIDTH)) u_term (
    .q      (q),
    .at_top (at_top),
    .term_n (term_n)
  );

  assign act        = rlc_pick(load_n, count_en_n, reload_en, at_top);
  assign evt_load   = (act == ACT_LOAD);
  assign evt_step   = (act == ACT_STEP);
  assign evt_wrap   = (act == ACT_WRAP);
  assign evt_reload = (act == ACT_RELOAD);
  assign evt_hold   = (act == ACT_HOLD);

  rlc_next_sel #(.WIDTH(WIDTH)) u_next (
    .q      (q),
    .preset (preset),
    .act    (act),
    .q_nxt  (q_nxt)
  );

  rlc_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .clear (clear),
    .d     (q_nxt),
    .q     (q)
  );
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clear,
  input logic             load_n,
  input logic             count_en_n,
  input logic             reload_en,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] q,
  input logic             term_n,
  input logic             evt_load,
  input logic             evt_step,
  input logic             evt_wrap,
  input logic             evt_reload,
  input logic             evt_hold
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (clear)
    !load_n |=> q == $past(preset)); // R1

  AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (clear)
    (load_n && !count_en_n && term_n) |=> q == ($past(q) + ONE)); // R2

  AST_HOLD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (clear)
    (load_n && count_en_n) |=> $stable(q)); // R3

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (clear)
    $countones({evt_load, evt_step, evt_wrap, evt_reload, evt_hold}) == 1); // R3

  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (clear)
    (load_n && !count_en_n && !reload_en && !term_n) |=> q == '0); // R5

  AST_TOP_RELOAD: assert property (@(posedge clk) disable iff (clear)
    (load_n && !count_en_n && reload_en && !term_n) |=> q == $past(preset)); // R6

  always @(posedge clk) begin
    if (clear) begin
      AST_CLEAR_FORCES: assert (q == '0 && term_n); // R7
    end
  end
endmodule

bind reload_counter rlc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .clear      (clear),
  .load_n     (load_n),
  .count_en_n (count_en_n),
  .reload_en  (reload_en),
  .preset     (preset),
  .q          (q),
  .term_n     (term_n),
  .evt_load   (evt_load),
  .evt_step   (evt_step),
  .evt_wrap   (evt_wrap),
  .evt_reload (evt_reload),
  .evt_hold   (evt_hold)
);

// File: tb/reload_counter_tb_top.sv
`timescale 1ns/1ps
module reload_counter_tb_top;
  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       load_n = 1'b1;
  logic       count_en_n = 1'b1;
  logic       reload_en = 1'b0;
  logic [7:0] preset = 8'h00;
  wire  [7:0] q;
  wire        term_n;

  int n_checks = 0;
  int n_fail   = 0;
  int m_q      = 0;

  always #4 clk = ~clk;

  reload_counter #(.WIDTH(8)) dut_i (
    .clk(clk), .clear(clear), .load_n(load_n), .count_en_n(count_en_n),
    .reload_en(reload_en), .preset(preset), .q(q), .term_n(term_n)
  );

  // Four-slice chain
  logic        c_load_n = 1'b1;
  logic        c_ce_n   = 1'b1;
  logic [31:0] c_preset = 32'h0;
  wire  [31:0] c_q;
  wire  [3:0]  c_tn;
  wire  [3:0]  c_en_n;

  assign c_en_n[0] = c_ce_n;
  for (genvar g = 1; g < 4; g++) begin : g_en
    assign c_en_n[g] = c_en_n[g-1] | c_tn[g-1];
  end
  for (genvar g = 0; g < 4; g++) begin : g_slice
    reload_counter #(.WIDTH(8)) cas_i (
      .clk(clk), .clear(clear), .load_n(c_load_n), .count_en_n(c_en_n[g]),
      .reload_en(1'b0), .preset(c_preset[8*g +: 8]), .q(c_q[8*g +: 8]),
      .term_n(c_tn[g])
    );
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: integer arithmetic modulo 256.
  function automatic int model_next(int cur, bit ld_n, bit ce_n, bit rl, int p);
    if (!ld_n) return p;
    if (ce_n)  return cur;
    if (cur == 255 && rl) return p;
    return (cur + 1) % 256;
  endfunction

  task automatic tick(input string tag);
    m_q = model_next(m_q, load_n, count_en_n, reload_en, int'(preset));
    @(posedge clk); #2;
    chk(tag, {24'h0, q}, m_q[31:0]);
    chk("R4 term_n", {31'h0, term_n}, (m_q == 255) ? 32'd0 : 32'd1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int prev, last, cm;
    #1;
    chk("R7 reset q", {24'h0, q}, 32'h0);
    chk("R7 reset term_n", {31'h0, term_n}, 32'd1);
    @(negedge clk); clear = 1'b0; m_q = 0;
    @(negedge clk);

    // Load wins over count and reload
    preset = 8'hF0; load_n = 1'b0; count_en_n = 1'b0; reload_en = 1'b1;
    tick("R1 load while counting");
    load_n = 1'b1; reload_en = 1'b0;

    // Free run across wrap twice
    for (int i = 0; i < 300; i++) begin
      prev = m_q;
      tick("R2 free run");
      if (prev == 255) chk("R5 wrap", {24'h0, q}, 32'h0);
    end

    // Reload with period check
    preset = 8'hF6; load_n = 1'b0; tick("R1 load F6");
    load_n = 1'b1; reload_en = 1'b1; last = -1;
    for (int i = 0; i < 40; i++) begin
      tick("R6 reload run");
      if (term_n == 1'b0) begin
        if (last >= 0) chk("R6 period", i - last, 32'd10);
        last = i;
      end
    end

    // Hold at all ones with reload armed
    preset = 8'hFF; load_n = 1'b0; tick("R1 load FF");
    load_n = 1'b1; count_en_n = 1'b1; preset = 8'h12;
    for (int i = 0; i < 5; i++) tick("R3 hold at top");
    count_en_n = 1'b0; tick("R6 reload after hold");
    chk("R6 reload value", {24'h0, q}, 32'h12);

    // Load while holding
    count_en_n = 1'b1; load_n = 1'b0; preset = 8'h5A; tick("R1 load while hold");
    load_n = 1'b1; count_en_n = 1'b0;
    tick("R2 step"); tick("R2 step");

    // Asynchronous clear mid-cycle
    @(posedge clk); #3; clear = 1'b1; m_q = 0;
    #1;
    chk("R7 async q", {24'h0, q}, 32'h0);
    chk("R7 async term_n", {31'h0, term_n}, 32'd1);
    @(posedge clk); #2;
    chk("R7 overrides count", {24'h0, q}, 32'h0);
    @(negedge clk); clear = 1'b0;
    #1; tick("R2 after clear");

    // Cascade carry
    c_preset = 32'h00FF_FFFF; c_load_n = 1'b0; c_ce_n = 1'b0;
    @(posedge clk); #2;
    chk("R1 cascade load", c_q, 32'h00FF_FFFF);
    chk("R8 cascade term before", {28'h0, c_tn}, 32'h8);
    c_load_n = 1'b1;
    @(posedge clk); #2;
    chk("R8 cascade carry", c_q, 32'h0100_0000);
    chk("R8 cascade term after", {28'h0, c_tn}, 32'hF);
    cm = 32'h0100_0000;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #2; cm++;
      chk("R8 cascade step", c_q, cm[31:0]);
    end
    c_ce_n = 1'b1;
    @(posedge clk); #2;
    chk("R8 cascade hold", c_q, cm[31:0]);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule